// File: doc/BRIEF.md
# Mixed-Width Event Timer Register Front End

This block sits between a simple request bus and the storage of a multi-channel event timer. It accepts reads and writes of 4 or 8 bytes. Every register behind it is 64 bits wide. A 4-byte access goes to the lower or the upper half of a register, as selected by address bit 2. The block drops any access of a different size, and any access that is not naturally aligned.

Writes are merged under a lane mask, so only the addressed half of a register changes. The block keeps four kinds of state itself: the global enable, and for each channel a configuration word, a 32-bit comparator and a 64-bit message word. In the configuration word, capability fields are read-only and the force-32-bit bit is always cleared. The main counter and the interrupt status live in the timer core. For these, the block issues a write strobe together with merged data, and it zero-extends their values on reads. Address 0x000 returns a constant capabilities word computed from the parameters.

Top module: `tmr_reg_if`

## Requirements
- R1: Only sizes 4 and 8 (size_i = byte count) are accepted. A request of any other size writes nothing, raises no strobe and returns rdata_o = 0.
- R2: A 4-byte access with addr_i[1:0] != 0, or an 8-byte access with addr_i[2:0] != 0, is rejected in the same way as R1.
- R3: A 4-byte write with addr_i[2] = 1 updates only bits 63:32 of the target, with data taken from wdata_i[31:0]. With addr_i[2] = 0 it updates only bits 31:0. An 8-byte write updates all 64 bits, subject to each register's own field rules.
- R4: A 4-byte read returns the selected half in rdata_o[31:0] and zeros in rdata_o[63:32]: bits 63:32 when addr_i[2] = 1, otherwise bits 31:0. An 8-byte read returns all 64 bits.
- R5: Offset 0x000 reads {tick_fs[31:0], 16'h8086, 3'b000, N_CH-1 in 5 bits, 8'h01}, where tick_fs = 10^15 >> TICK_LOG2. Bit 13 = 0 marks a 32-bit counter. Writes to this offset have no effect.
- R6: The global config word at 0x010 stores only bit 0, the enable, which drives enable_o and resets to 0. Bit 1, the legacy-routing bit, and all other bits always read 0.
- R7: The configuration word of channel n sits at 0x100+0x20·n. Writable bits are 1, 2, 3, 6, 13:9 and 14. Bits 63:32 (route capability, reset ROUTE_CAP), bit 4 (reset 1), bit 5 (reset 0) and bit 15 (reset 1) are read-only. Bit 8, force-32-bit, always reads 0.
- R8: A read of the counter at 0x0F0 returns {32'b0, count_i}. An accepted write raises cnt_we_o in the request cycle, with cnt_wdata_o equal to the low 32 bits of the merge into {32'b0, count_i}.
- R9: A read of the status at 0x020 returns status_i zero-extended. An accepted write raises sts_we_o in the request cycle, with sts_clr_o = status_i & merged write data [N_CH-1:0].
- R10: The comparator at 0x108+0x20·n holds 32 bits, resets to 0xFFFFFFFF and reads zero-extended. The message word at 0x110+0x20·n holds 64 bits and resets to 0. Both take merged writes.
- R11: Unmapped offsets read as 0. These are all gaps, the sub-offset 0x18 of each channel, and everything at or above 0x100+0x20·N_CH.
- R12: Each request, accepted or rejected, is answered by ready_o high for exactly the following cycle. Read data is valid on rdata_o in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| size_i | input | 4 | Access size in bytes |
| wdata_i | input | 64 | Write data (4-byte writes use bits 31:0) |
| ready_o | output | 1 | Completion pulse, one cycle after req_i |
| rdata_o | output | 64 | Read data, valid with ready_o |
| count_i | input | 32 | Current main counter value |
| status_i | input | N_CH | Current per-channel interrupt status |
| enable_o | output | 1 | Global enable |
| cnt_we_o | output | 1 | Counter write strobe |
| cnt_wdata_o | output | 32 | Merged counter value |
| sts_we_o | output | 1 | Status write strobe |
| sts_clr_o | output | N_CH | Status bits to clear |
| ch_cfg_o | output | 64·N_CH | Channel configuration words, channel n at bits 64n+63:64n |
| ch_cmp_o | output | 32·N_CH | Channel comparators |
| ch_msg_o | output | 64·N_CH | Channel message words |

## Verification
The bench builds the block with N_CH = 3 and ADDR_W = 12. With these values the whole 4 KiB offset space can be read in 512 word steps against an arithmetic model. The sweep covers the edge just past the last channel, the unused sub-offset of each channel and every gap. All sixteen size codes are crossed with all eight byte offsets inside one message register, for both writes and reads. This checks the acceptance rule, the half steering and the read-back lanes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CH_BASE   = 'h100;
  localparam int unsigned CH_STRIDE = 'h20;
  localparam int unsigned OFF_CAPS  = 'h000;
  localparam int unsigned OFF_GCFG  = 'h010;
  localparam int unsigned OFF_STS   = 'h020;
  localparam int unsigned OFF_CNT   = 'h0F0;

  typedef enum logic [1:0] {
    SUB_CFG  = 2'd0,
    SUB_CMP  = 2'd1,
    SUB_MSG  = 2'd2,
    SUB_NONE = 2'd3
  } ch_sub_e;

  // channel config: writable bits 1,2,3,6,13:9,14
  localparam logic [63:0] CFG_WR_MASK = 64'h0000_0000_0000_7E4E;
  // read-only capability bits in the low word: bit 15 and bit 4 set
  localparam logic [31:0] CFG_RST_LO  = 32'h0000_8010;

  function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                          input logic [63:0] new_v,
                                          input logic [63:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction
endpackage

// File: rtl/tmr_lane_align.sv
module tmr_lane_align (
  input  logic [3:0]  size_i,
  input  logic [2:0]  off_i,
  input  logic [63:0] wdata_i,
  output logic        ok_o,
  output logic        hi_o,
  output logic        wide_o,
  output logic [63:0] mask_o,
  output logic [63:0] data_o
);
  always_comb begin
    wide_o = (size_i == 4'd8);
    ok_o   = (wide_o && off_i == 3'd0) || (size_i == 4'd4 && off_i[1:0] == 2'd0);
    hi_o   = (size_i == 4'd4) && off_i[2];
    if (!ok_o) begin
      mask_o = '0;
      data_o = '0;
    end else if (wide_o) begin
      mask_o = '1;
      data_o = wdata_i;
    end else if (hi_o) begin
      mask_o = {32'hFFFF_FFFF, 32'h0};
      data_o = {wdata_i[31:0], 32'h0};
    end else begin
      mask_o = {32'h0, 32'hFFFF_FFFF};
      data_o = {32'h0, wdata_i[31:0]};
    end
  end

  always_comb begin
    p_half_mask_r3: assert (!(ok_o && !wide_o) || $countones(mask_o) == 32);
    p_reject_no_mask_r2: assert (ok_o || mask_o == '0);
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_cfg_i,
  input  logic        wr_cmp_i,
  input  logic        wr_msg_i,
  input  logic [63:0] mask_i,
  input  logic [63:0] data_i,
  output logic [63:0] cfg_o,
  output logic [31:0] cmp_o,
  output logic [63:0] msg_o
);
  logic [63:0] cfg_q, msg_q;
  logic [31:0] cmp_q;
  logic [63:0] cfg_wm;

  assign cfg_wm = mask_i & CFG_WR_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= {ROUTE_CAP, CFG_RST_LO};
      cmp_q <= 32'hFFFF_FFFF;
      msg_q <= '0;
    end else begin
      if (wr_cfg_i) cfg_q <= merge64(cfg_q, data_i, cfg_wm);
      if (wr_cmp_i) cmp_q <= (cmp_q & ~mask_i[31:0]) | (data_i[31:0] & mask_i[31:0]);
      if (wr_msg_i) msg_q <= merge64(msg_q, data_i, mask_i);
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
  assign msg_o = msg_q;

  p_ro_route_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_q[63:32]));
  p_ro_caps_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable({cfg_q[15], cfg_q[8], cfg_q[5:4]}));
  p_cmp_hi_write_keeps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmp_i && mask_i[31:0] == 32'h0) |=> $stable(cmp_q));
  p_msg_lo_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_msg_i && mask_i[31:0] == 32'h0) |=> $stable(msg_q[31:0]));
endmodule

// File: rtl/tmr_reg_if.sv
module tmr_reg_if
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000,
  parameter logic [15:0] VENDOR_ID = 16'h8086,
  parameter int unsigned TICK_LOG2 = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [3:0]           size_i,
  input  logic [63:0]          wdata_i,
  output logic                 ready_o,
  output logic [63:0]          rdata_o,
  input  logic [31:0]          count_i,
  input  logic [N_CH-1:0]      status_i,
  output logic                 enable_o,
  output logic                 cnt_we_o,
  output logic [31:0]          cnt_wdata_o,
  output logic                 sts_we_o,
  output logic [N_CH-1:0]      sts_clr_o,
  output logic [N_CH*64-1:0]   ch_cfg_o,
  output logic [N_CH*32-1:0]   ch_cmp_o,
  output logic [N_CH*64-1:0]   ch_msg_o
);
  localparam logic [63:0] TICK_FS = 64'd1000000000000000 >> TICK_LOG2;
  localparam logic [63:0] CAPS    = {TICK_FS[31:0], VENDOR_ID, 3'b000,
                                     5'(N_CH - 1), 8'h01};
  localparam int unsigned CH_END  = CH_BASE + CH_STRIDE * N_CH;

  logic        acc_ok, acc_hi, acc_wide;
  logic [63:0] acc_mask, acc_data;
  logic [31:0] word_a;
  logic        hit_caps, hit_gcfg, hit_sts, hit_cnt, in_ch;
  logic [4:0]  ch_sel;
  ch_sub_e     ch_sub;
  logic        wr;
  logic        en_q, ready_q;
  logic [63:0] rdata_q, rd_full, rd_lane;
  logic [63:0] cfg_a [N_CH];
  logic [31:0] cmp_a [N_CH];
  logic [63:0] msg_a [N_CH];

  tmr_lane_align u_lane (
    .size_i (size_i),
    .off_i  (addr_i[2:0]),
    .wdata_i(wdata_i),
    .ok_o   (acc_ok),
    .hi_o   (acc_hi),
    .wide_o (acc_wide),
    .mask_o (acc_mask),
    .data_o (acc_data)
  );

  // decode on 8-byte words
  assign word_a   = 32'({addr_i[ADDR_W-1:3], 3'b000});
  assign hit_caps = (word_a == OFF_CAPS);
  assign hit_gcfg = (word_a == OFF_GCFG);
  assign hit_sts  = (word_a == OFF_STS);
  assign hit_cnt  = (word_a == OFF_CNT);
  assign in_ch    = (word_a >= CH_BASE) && (word_a < CH_END);
  assign ch_sel   = 5'((word_a - CH_BASE) >> 5);
  assign ch_sub   = ch_sub_e'(2'((word_a - CH_BASE) >> 3));
  assign wr       = req_i && we_i && acc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   en_q <= 1'b0;
    else if (wr && hit_gcfg && acc_mask[0]) en_q <= acc_data[0];
  end
  assign enable_o = en_q;

  always_comb begin
    logic [31:0] cnt_m;
    cnt_m       = (count_i & ~acc_mask[31:0]) | (acc_data[31:0] & acc_mask[31:0]);
    cnt_we_o    = wr && hit_cnt;
    cnt_wdata_o = cnt_m;
    sts_we_o    = wr && hit_sts;
    sts_clr_o   = sts_we_o ? (status_i & acc_data[N_CH-1:0]) : '0;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic sel;
    assign sel = in_ch && (ch_sel == 5'(g));
    tmr_chan_regs #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_cfg_i(wr && sel && ch_sub == SUB_CFG),
      .wr_cmp_i(wr && sel && ch_sub == SUB_CMP),
      .wr_msg_i(wr && sel && ch_sub == SUB_MSG),
      .mask_i  (acc_mask),
      .data_i  (acc_data),
      .cfg_o   (cfg_a[g]),
      .cmp_o   (cmp_a[g]),
      .msg_o   (msg_a[g])
    );
    assign ch_cfg_o[g*64 +: 64] = cfg_a[g];
    assign ch_cmp_o[g*32 +: 32] = cmp_a[g];
    assign ch_msg_o[g*64 +: 64] = msg_a[g];
  end

  always_comb begin
    rd_full = '0;
    if (hit_caps)      rd_full = CAPS;
    else if (hit_gcfg) rd_full = {63'h0, en_q};
    else if (hit_sts)  rd_full = 64'(status_i);
    else if (hit_cnt)  rd_full = {32'h0, count_i};
    else if (in_ch) begin
      for (int c = 0; c < N_CH; c++) begin
        if (ch_sel == 5'(c)) begin
          case (ch_sub)
            SUB_CFG: rd_full = cfg_a[c];
            SUB_CMP: rd_full = {32'h0, cmp_a[c]};
            SUB_MSG: rd_full = msg_a[c];
            default: rd_full = '0;
          endcase
        end
      end
    end
    if (acc_wide)    rd_lane = rd_full;
    else if (acc_hi) rd_lane = {32'h0, rd_full[63:32]};
    else             rd_lane = {32'h0, rd_full[31:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_i;
      rdata_q <= (req_i && !we_i && acc_ok) ? rd_lane : '0;
    end
  end
  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  p_ready_after_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  p_no_spurious_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  p_bad_read_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !acc_ok) |=> rdata_o == 64'h0);
  p_bad_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !acc_ok) |-> (!cnt_we_o && !sts_we_o));
  p_clr_pending_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_o & ~status_i) == '0);
  p_half_read_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 4'd4) |=> rdata_o[63:32] == 32'h0);
endmodule

// File: tb/tb_tmr_reg_if.sv
module tb_tmr_reg_if;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int AW = 12;
  localparam logic [31:0] RCAP = 32'h00F0_0000;
  localparam logic [63:0] TICK = 64'd1000000000000000 / 64'd16777216;
  localparam logic [63:0] EXP_CAPS = {TICK[31:0], 16'h8086, 3'b000, 5'(NCH - 1), 8'h01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] size = 4'd0;
  logic [63:0] wdata = '0;
  logic [31:0] count = 32'h0;
  logic [NCH-1:0] sts = '0;
  logic ready, enable, cnt_we, sts_we;
  logic [63:0] rdata;
  logic [31:0] cnt_wd;
  logic [NCH-1:0] sts_clr;
  logic [NCH*64-1:0] cfg_flat, msg_flat;
  logic [NCH*32-1:0] cmp_flat;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] rd_val;
  logic s_cnt_we, s_sts_we;
  logic [31:0] s_cnt_wd;
  logic [NCH-1:0] s_sts_clr;

  logic [63:0] m_cfg [NCH];
  logic [31:0] m_cmp [NCH];
  logic [63:0] m_msg [NCH];
  logic m_en;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_reg_if #(.N_CH(NCH), .ADDR_W(AW), .ROUTE_CAP(RCAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .count_i(count), .status_i(sts), .enable_o(enable), .cnt_we_o(cnt_we),
    .cnt_wdata_o(cnt_wd), .sts_we_o(sts_we), .sts_clr_o(sts_clr),
    .ch_cfg_o(cfg_flat), .ch_cmp_o(cmp_flat), .ch_msg_o(msg_flat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit lane_ok(input logic [3:0] sz, input logic [2:0] off);
    return (sz == 4'd8 && off == 3'd0) || (sz == 4'd4 && off[1:0] == 2'd0);
  endfunction

  function automatic logic [63:0] lane_view(input logic [63:0] full,
                                            input logic [3:0] sz, input logic [2:0] off);
    if (!lane_ok(sz, off)) return 64'h0;
    if (sz == 4'd8) return full;
    return off[2] ? (full >> 32) : (full & 64'hFFFF_FFFF);
  endfunction

  function automatic logic [63:0] model_read(input logic [AW-1:0] a);
    int w, idx, sub;
    w = int'(a) & ~7;
    if (w == 'h000) return EXP_CAPS;
    if (w == 'h010) return {63'h0, m_en};
    if (w == 'h020) return 64'(sts);
    if (w == 'h0F0) return {32'h0, count};
    if (w >= 'h100 && w < 'h100 + 'h20 * NCH) begin
      idx = (w - 'h100) / 'h20;
      sub = ((w - 'h100) % 'h20) / 8;
      if (sub == 0) return m_cfg[idx];
      if (sub == 1) return {32'h0, m_cmp[idx]};
      if (sub == 2) return m_msg[idx];
    end
    return 64'h0;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [3:0] sz,
                             input logic [63:0] d);
    logic [63:0] m, dd, t;
    int w, idx, sub;
    if (!lane_ok(sz, a[2:0])) return;
    m  = (sz == 4'd8) ? 64'hFFFF_FFFF_FFFF_FFFF : (64'hFFFF_FFFF << (a[2] ? 32 : 0));
    dd = (sz == 4'd8) ? d : ((d & 64'hFFFF_FFFF) << (a[2] ? 32 : 0));
    w  = int'(a) & ~7;
    if (w == 'h010) begin
      t = ({63'h0, m_en} & ~m) | (dd & m);
      m_en = t[0];
    end else if (w >= 'h100 && w < 'h100 + 'h20 * NCH) begin
      idx = (w - 'h100) / 'h20;
      sub = ((w - 'h100) % 'h20) / 8;
      if (sub == 0) begin
        m = m & 64'h7E4E;
        m_cfg[idx] = (m_cfg[idx] & ~m) | (dd & m);
      end else if (sub == 1) begin
        t = ({32'h0, m_cmp[idx]} & ~m) | (dd & m);
        m_cmp[idx] = t[31:0];
      end else if (sub == 2) begin
        m_msg[idx] = (m_msg[idx] & ~m) | (dd & m);
      end
    end
  endtask

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [3:0] sz,
                      input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    #1;
    s_cnt_we = cnt_we; s_cnt_wd = cnt_wd; s_sts_we = sts_we; s_sts_clr = sts_clr;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd_val = rdata;
    chk(ready === 1'b1, "R12 ready after request", 64'(ready), 64'h1);
    if (w) model_write(a, sz, d);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [3:0] sz, input string tag);
    logic [63:0] e;
    e = lane_view(model_read(a), sz, a[2:0]);
    xfer(1'b0, a, sz, 64'h0);
    chk(rd_val === e, tag, rd_val, e);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_cfg[i] = {RCAP, 32'h0000_8010};
      m_cmp[i] = 32'hFFFF_FFFF;
      m_msg[i] = 64'h0;
    end
    m_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready === 1'b0 && rdata === 64'h0, "R12 reset outputs", rdata, 64'h0);
    chk(enable === 1'b0, "R6 reset enable", 64'(enable), 64'h0);
    chk(cmp_flat[31:0] === 32'hFFFF_FFFF, "R10 reset comparator", 64'(cmp_flat[31:0]), 64'hFFFF_FFFF);
    chk(cfg_flat[63:0] === {RCAP, 32'h8010}, "R7 reset config", cfg_flat[63:0], {RCAP, 32'h8010});
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b0, "R12 idle ready low", 64'(ready), 64'h0);

    // R5 capabilities
    rd_chk(12'h000, 4'd8, "R5 caps 8-byte");
    rd_chk(12'h000, 4'd4, "R5 caps low half");
    rd_chk(12'h004, 4'd4, "R5 caps tick period");
    xfer(1'b1, 12'h000, 4'd8, 64'h0);
    rd_chk(12'h000, 4'd8, "R5 caps after write");

    // R1 R2 R3 R4: size x offset sweep inside message register of channel 1
    for (int s = 0; s < 16; s++) begin
      for (int o = 0; o < 8; o++) begin
        logic [63:0] pat;
        pat = {8'(s), 8'(o), 48'hC0DE_5A5A_1234} ^ (64'h0101_0101_0101_0101 * 64'(s * 8 + o));
        xfer(1'b1, AW'(12'h130 + o), 4'(s), pat);
        chk(!s_cnt_we && !s_sts_we, "R1 no strobe off target", 64'(s_cnt_we), 64'h0);
        rd_chk(12'h130, 4'd8, "R3 merged write read-back");
        rd_chk(AW'(12'h130 + o), 4'(s), "R2 R4 lane read");
      end
    end

    // R6 global config
    xfer(1'b1, 12'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(12'h010, 4'd8, "R6 legacy bit reads 0");
    chk(enable === 1'b1, "R6 enable set", 64'(enable), 64'h1);
    xfer(1'b1, 12'h014, 4'd4, 64'h0);
    chk(enable === 1'b1, "R6 upper write keeps enable", 64'(enable), 64'h1);
    xfer(1'b1, 12'h012, 4'd4, 64'h0);
    chk(enable === 1'b1, "R2 misaligned config write ignored", 64'(enable), 64'h1);
    xfer(1'b1, 12'h010, 4'd4, 64'h2);
    chk(enable === 1'b0, "R6 enable cleared", 64'(enable), 64'h0);

    // R7 channel config
    xfer(1'b1, 12'h100, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(12'h100, 4'd8, "R7 cfg all ones");
    chk(cfg_flat[63:0] === {RCAP, 32'h0000_FE5E}, "R7 cfg port", cfg_flat[63:0], {RCAP, 32'h0000_FE5E});
    xfer(1'b1, 12'h144, 4'd4, 64'h0);
    rd_chk(12'h140, 4'd8, "R7 cfg upper read-only");
    xfer(1'b1, 12'h140, 4'd8, 64'h0);
    rd_chk(12'h140, 4'd8, "R7 cfg zeros keep caps");

    // R10 comparator and message
    xfer(1'b1, 12'h148, 4'd8, 64'hDEAD_BEEF_CAFE_F00D);
    rd_chk(12'h148, 4'd8, "R10 comparator 32-bit");
    xfer(1'b1, 12'h14C, 4'd4, 64'h1234_5678);
    rd_chk(12'h148, 4'd8, "R10 comparator upper write");
    rd_chk(12'h14C, 4'd4, "R10 comparator upper read");
    xfer(1'b1, 12'h154, 4'd4, 64'hA5A5_0001);
    rd_chk(12'h150, 4'd8, "R10 message upper half");

    // R8 counter
    count = 32'h8000_0042;
    xfer(1'b1, 12'h0F0, 4'd4, 64'h1234_5678);
    chk(s_cnt_we === 1'b1 && s_cnt_wd === 32'h1234_5678, "R8 counter low write", 64'(s_cnt_wd), 64'h1234_5678);
    xfer(1'b1, 12'h0F4, 4'd4, 64'hFFFF_FFFF);
    chk(s_cnt_we === 1'b1 && s_cnt_wd === 32'h8000_0042, "R8 counter upper write", 64'(s_cnt_wd), 64'h8000_0042);
    xfer(1'b1, 12'h0F0, 4'd2, 64'h0);
    chk(s_cnt_we === 1'b0, "R1 counter bad size", 64'(s_cnt_we), 64'h0);
    rd_chk(12'h0F0, 4'd8, "R8 counter read");
    rd_chk(12'h0F4, 4'd4, "R8 counter upper zero");

    // R9 status
    sts = 3'b101;
    xfer(1'b1, 12'h020, 4'd8, 64'h7);
    chk(s_sts_we === 1'b1 && s_sts_clr === 3'b101, "R9 clear pending", 64'(s_sts_clr), 64'h5);
    xfer(1'b1, 12'h020, 4'd4, 64'h6);
    chk(s_sts_clr === 3'b100, "R9 clear subset", 64'(s_sts_clr), 64'h4);
    xfer(1'b1, 12'h024, 4'd4, 64'h7);
    chk(s_sts_we === 1'b1 && s_sts_clr === 3'b000, "R9 upper write clears none", 64'(s_sts_clr), 64'h0);
    rd_chk(12'h020, 4'd8, "R9 status read");

    // R11 full map sweep
    for (int a = 0; a < 4096; a += 8) rd_chk(AW'(a), 4'd8, "R11 map sweep");
    rd_chk(12'h11C, 4'd4, "R11 unused sub-offset");

    @(negedge clk);
    chk(ready === 1'b0, "R12 single pulse", 64'(ready), 64'h0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule